// File: doc/BRIEF.md
# Masked burst address counter

This block produces the address for one port of a synchronous dual-port memory. It holds a 17-bit burst counter, a mask register and a mirror register. The mask register picks which low bits of the counter take part in counting and wrapping. The mirror register keeps the last address that was loaded from outside. Bits above the mask never change while the counter runs. When the counting part has reached its top value, the next increment reloads the mirror value, so a burst repeats for as long as counting stays on.

A select input chooses whether the load and clear controls act on the counter or on the mask. All controls are synchronous. Master reset has the highest priority, then counter clear, then load, then count enable. A readback port shows either the counter or the mask. An active-low terminal flag marks the cycle in which an increment has brought the counting part to its top value. If bit 0 of the mask is 0, the counter steps by two and keeps bit 0 fixed. Two ports can use this to split a wide word between even and odd addresses.

Top module: `masked_burst_agen`

## Requirements
- R1: When `mrst` is high at a clock edge, the counter and the mirror become 0, the mask becomes 1FFFF hex and `term_n` becomes 1. This happens whatever the other controls are doing.
- R2: With `sel_cnt`=1 and `cnt_clr`=1, the next edge clears the counter bits whose mask bit is 1 and leaves the other bits unchanged. This takes priority over `ld` and `inc`.
- R3: With `sel_cnt`=1, `ld`=1 and `cnt_clr`=0, the next edge loads `addr_in` into both the counter and the mirror.
- R4: With `sel_cnt`=1, `inc`=1 and neither `ld` nor `cnt_clr` high, the part of the counter under the mask advances by one per edge when mask bit 0 is 1. Counter bits whose mask bit is 0 stay unchanged.
- R5: When mask bit 0 is 0, each increment adds two to the part under the mask, and counter bit 0 keeps its value.
- R6: An increment taken while (counter AND mask) equals the mask loads the mirror value into the counter instead of stepping.
- R7: `term_n` is 0 for exactly the cycle after an increment step (not a mirror reload) that leaves (counter AND mask) equal to the mask. In every other cycle it is 1.
- R8: With `sel_cnt`=1 and `cnt_clr`, `ld` and `inc` all 0, the counter keeps its value.
- R9: With `sel_cnt`=0, `ld`=1 loads `addr_in` into the mask at the next edge. While `sel_cnt`=0 the counter keeps its value, and `cnt_clr` and `inc` are ignored.
- R10: `rdbk_data` shows the counter when `rdbk`=1 and `sel_cnt`=1. It shows the mask when `rdbk`=1 and `sel_cnt`=0. It is 0 when `rdbk`=0. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| mrst | input | 1 | Synchronous master reset, active high |
| cnt_clr | input | 1 | Clear the part of the counter under the mask (when sel_cnt=1) |
| ld | input | 1 | Load strobe: counter and mirror if sel_cnt=1, mask if sel_cnt=0 |
| inc | input | 1 | Count enable (when sel_cnt=1) |
| sel_cnt | input | 1 | 1 = counter operations, 0 = mask operations |
| rdbk | input | 1 | Readback request |
| addr_in | input | 17 | External address or mask value |
| addr_out | output | 17 | Current counter address |
| rdbk_data | output | 17 | Readback value |
| term_n | output | 1 | Terminal count flag, active low |

## Verification
The counter is run with three masks. The full mask starting at 1FFFD shows the wrap at the top of the whole address space and the reload from the mirror. A four-bit mask under a nonzero upper address shows that the upper bits stay fixed and that the wrap returns to the loaded value rather than to zero. A mask with bit 0 clear, loaded at an odd address, separates stepping by two from stepping by one and shows bit 0 held. Clears, holds, controls given with the mask selected, and resets given together with other controls show each priority and each ignored input at the address and readback outputs.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;
  parameter int ADDR_W = 17;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ALL_ONES = '1;

  typedef enum logic [2:0] {
    OP_HOLD, OP_MRST, OP_CLR, OP_LOAD, OP_INC, OP_MLOAD
  } op_e;

  // step size chosen by mask bit 0
  function automatic addr_t step_of(addr_t m);
    return m[0] ? addr_t'(1) : addr_t'(2);
  endfunction

  // counting part has reached its top value
  function automatic logic at_top(addr_t c, addr_t m);
    return (c & m) == m;
  endfunction

  // advance the bits under the mask, keep the rest
  function automatic addr_t bump(addr_t c, addr_t m);
    addr_t s;
    s = c + step_of(m);
    return (c & ~m) | (s & m);
  endfunction

  // clear the bits under the mask
  function automatic addr_t clr_low(addr_t c, addr_t m);
    return c & ~m;
  endfunction
endpackage

// File: rtl/mbc_decode.sv
`timescale 1ns/1ps
module mbc_decode
  import mbc_pkg::*;
(
  input  logic mrst,
  input  logic cnt_clr,
  input  logic ld,
  input  logic inc,
  input  logic sel_cnt,
  output op_e  op
);
  always_comb begin
    if (mrst)                   op = OP_MRST;
    else if (!sel_cnt)          op = ld ? OP_MLOAD : OP_HOLD;
    else if (cnt_clr)           op = OP_CLR;
    else if (ld)                op = OP_LOAD;
    else if (inc)               op = OP_INC;
    else                        op = OP_HOLD;
  end
endmodule

// File: rtl/mbc_mask.sv
`timescale 1ns/1ps
module mbc_mask
  import mbc_pkg::*;
(
  input  logic  clk,
  input  op_e   op,
  input  addr_t din,
  output addr_t mask_q
);
  always_ff @(posedge clk) begin
    if (op == OP_MRST)       mask_q <= ALL_ONES;
    else if (op == OP_MLOAD) mask_q <= din;
  end
endmodule

// File: rtl/mbc_counter.sv
`timescale 1ns/1ps
module mbc_counter
  import mbc_pkg::*;
(
  input  logic  clk,
  input  op_e   op,
  input  addr_t din,
  input  addr_t mask,
  output addr_t cnt_q,
  output addr_t mir_q,
  output logic  wrap_evt,
  output logic  term_set,
  output logic  term_n
);
  addr_t cnt_d, mir_d, stepped;

  always_comb begin
    stepped  = bump(cnt_q, mask);
    wrap_evt = (op == OP_INC) && at_top(cnt_q, mask);
    term_set = (op == OP_INC) && !wrap_evt && at_top(stepped, mask);
    cnt_d    = cnt_q;
    mir_d    = mir_q;
    case (op)
      OP_MRST: begin cnt_d = '0; mir_d = '0; end
      OP_CLR:  cnt_d = clr_low(cnt_q, mask);
      OP_LOAD: begin cnt_d = din; mir_d = din; end
      OP_INC:  cnt_d = wrap_evt ? mir_q : stepped;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    cnt_q  <= cnt_d;
    mir_q  <= mir_d;
    term_n <= !term_set;
  end
endmodule

// File: rtl/mbc_readback.sv
`timescale 1ns/1ps
module mbc_readback
  import mbc_pkg::*;
(
  input  logic  rdbk,
  input  logic  sel_cnt,
  input  addr_t cnt,
  input  addr_t mask,
  output addr_t data
);
  always_comb begin
    if (!rdbk)        data = '0;
    else if (sel_cnt) data = cnt;
    else              data = mask;
  end
endmodule

// File: rtl/masked_burst_agen.sv
`timescale 1ns/1ps
module masked_burst_agen
  import mbc_pkg::*;
(
  input  logic              clk,
  input  logic              mrst,
  input  logic              cnt_clr,
  input  logic              ld,
  input  logic              inc,
  input  logic              sel_cnt,
  input  logic              rdbk,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] rdbk_data,
  output logic              term_n
);
  op_e   op;
  addr_t mask_q, cnt_q, mir_q;
  logic  wrap_evt, term_set;

  mbc_decode u_dec (
    .mrst(mrst), .cnt_clr(cnt_clr), .ld(ld), .inc(inc),
    .sel_cnt(sel_cnt), .op(op)
  );

  mbc_mask u_mask (.clk(clk), .op(op), .din(addr_in), .mask_q(mask_q));

  mbc_counter u_cnt (
    .clk(clk), .op(op), .din(addr_in), .mask(mask_q),
    .cnt_q(cnt_q), .mir_q(mir_q), .wrap_evt(wrap_evt),
    .term_set(term_set), .term_n(term_n)
  );

  mbc_readback u_rb (
    .rdbk(rdbk), .sel_cnt(sel_cnt), .cnt(cnt_q), .mask(mask_q),
    .data(rdbk_data)
  );

  assign addr_out = cnt_q;
endmodule

// File: rtl/mbc_chk.sv
`timescale 1ns/1ps
module mbc_chk
  import mbc_pkg::*;
(
  input logic  clk,
  input logic  mrst,
  input logic  cnt_clr,
  input logic  ld,
  input logic  inc,
  input logic  sel_cnt,
  input logic  rdbk,
  input addr_t addr_in,
  input addr_t addr_out,
  input addr_t rdbk_data,
  input logic  term_n,
  input addr_t mask_q,
  input addr_t mir_q,
  input logic  wrap_evt
);
  logic plain_inc;
  assign plain_inc = sel_cnt && inc && !ld && !cnt_clr && !wrap_evt;

  // R1
  mrst_state_chk: assert property (@(posedge clk)
    mrst |=> (addr_out == '0) && (mask_q == ALL_ONES) && (mir_q == '0) && term_n);

  // R2
  clr_low_chk: assert property (@(posedge clk) disable iff (mrst)
    (sel_cnt && cnt_clr) |=> ((addr_out & mask_q) == '0) &&
      ((addr_out & ~mask_q) == ($past(addr_out) & ~mask_q)));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (mrst)
    (sel_cnt && ld && !cnt_clr) |=> (addr_out == $past(addr_in)) && (mir_q == $past(addr_in)));

  // R4
  high_bits_fixed_chk: assert property (@(posedge clk) disable iff (mrst)
    plain_inc |=> ((addr_out ^ $past(addr_out)) & ~mask_q) == '0);

  // R5
  even_step_bit0_chk: assert property (@(posedge clk) disable iff (mrst)
    (plain_inc && !mask_q[0]) |=> addr_out[0] == $past(addr_out[0]));

  // R6
  wrap_reload_chk: assert property (@(posedge clk) disable iff (mrst)
    wrap_evt |=> addr_out == $past(mir_q));

  // R7
  term_at_top_chk: assert property (@(posedge clk) disable iff (mrst)
    !term_n |-> (addr_out & mask_q) == mask_q);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (mrst)
    (sel_cnt && !cnt_clr && !ld && !inc) |=> $stable(addr_out));

  // R9
  mask_side_chk: assert property (@(posedge clk) disable iff (mrst)
    !sel_cnt |=> $stable(addr_out));

  // R10
  rdbk_chk: assert property (@(posedge clk) disable iff (mrst)
    rdbk_data == (!rdbk ? '0 : (sel_cnt ? addr_out : mask_q)));
endmodule

bind masked_burst_agen mbc_chk u_chk (
  .clk(clk), .mrst(mrst), .cnt_clr(cnt_clr), .ld(ld), .inc(inc),
  .sel_cnt(sel_cnt), .rdbk(rdbk), .addr_in(addr_in), .addr_out(addr_out),
  .rdbk_data(rdbk_data), .term_n(term_n), .mask_q(mask_q), .mir_q(mir_q),
  .wrap_evt(wrap_evt)
);

// File: tb/tb_masked_burst_agen.sv
`timescale 1ns/1ps
module tb_masked_burst_agen;
  logic        clk = 0;
  logic        mrst = 1, cnt_clr = 0, ld = 0, inc = 0, sel_cnt = 1, rdbk = 0;
  logic [16:0] addr_in = '0;
  logic [16:0] addr_out, rdbk_data;
  logic        term_n;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  masked_burst_agen dut (
    .clk(clk), .mrst(mrst), .cnt_clr(cnt_clr), .ld(ld), .inc(inc),
    .sel_cnt(sel_cnt), .rdbk(rdbk), .addr_in(addr_in),
    .addr_out(addr_out), .rdbk_data(rdbk_data), .term_n(term_n)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic idle();
    cnt_clr = 0; ld = 0; inc = 0; sel_cnt = 1; rdbk = 0; mrst = 0;
  endtask

  task automatic set_mask(logic [16:0] m);
    idle(); sel_cnt = 0; ld = 1; addr_in = m; cyc(); idle();
  endtask

  task automatic t_reset();
    mrst = 1; cyc(); cyc(); idle();
    chk("R1 counter", addr_out, 17'h0);
    chk("R1 term_n", {16'h0, term_n}, 17'h1);
    sel_cnt = 0; rdbk = 1; #1;
    chk("R1 mask", rdbk_data, 17'h1FFFF);
    idle();
  endtask

  task automatic t_full_burst();
    logic [16:0] exp_a [4] = '{17'h1FFFE, 17'h1FFFF, 17'h1FFFD, 17'h1FFFE};
    logic        exp_t [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    ld = 1; addr_in = 17'h1FFFD; cyc();
    chk("R3 load", addr_out, 17'h1FFFD);
    ld = 0; inc = 1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R4/R6 full mask", addr_out, exp_a[i]);
      chk("R7 term_n", {16'h0, term_n}, {16'h0, exp_t[i]});
    end
    idle();
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R8 hold", addr_out, 17'h1FFFE);
    end
  endtask

  task automatic t_nibble();
    logic [16:0] exp_a [4] = '{17'h012AD, 17'h012AE, 17'h012AF, 17'h012AC};
    logic        exp_t [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    set_mask(17'h0000F);
    chk("R9 mask load leaves counter", addr_out, 17'h1FFFE);
    sel_cnt = 0; rdbk = 1; #1;
    chk("R10 mask readback", rdbk_data, 17'h0000F);
    inc = 1; cnt_clr = 1; cyc();
    chk("R9 inc/clr ignored", addr_out, 17'h1FFFE);
    idle(); ld = 1; addr_in = 17'h012AC; cyc();
    rdbk = 1; #1;
    chk("R10 counter readback", rdbk_data, 17'h012AC);
    ld = 0; rdbk = 0; inc = 1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R4/R6 nibble mask", addr_out, exp_a[i]);
      chk("R7 term_n nibble", {16'h0, term_n}, {16'h0, exp_t[i]});
    end
    #1;
    chk("R10 no request", rdbk_data, 17'h0);
    idle();
  endtask

  task automatic t_step2();
    logic [16:0] exp_a [6] = '{17'h00107, 17'h00109, 17'h0010B,
                               17'h0010D, 17'h0010F, 17'h00105};
    set_mask(17'h0000E);
    ld = 1; addr_in = 17'h00105; cyc();
    ld = 0; inc = 1;
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk("R5 step by two", addr_out, exp_a[i]);
      if (i == 4) chk("R7 term_n step2", {16'h0, term_n}, 17'h0);
    end
    idle();
  endtask

  task automatic t_clear();
    set_mask(17'h000FF);
    ld = 1; addr_in = 17'h14567; cyc();
    ld = 1; inc = 1; cnt_clr = 1; addr_in = 17'h00000; cyc();
    chk("R2 clear beats load/inc", addr_out, 17'h14500);
    idle();
  endtask

  task automatic t_mrst_prio();
    mrst = 1; ld = 1; inc = 1; addr_in = 17'h0AAAA; cyc();
    idle();
    chk("R1 reset beats load", addr_out, 17'h0);
    sel_cnt = 0; rdbk = 1; #1;
    chk("R1 mask after reset", rdbk_data, 17'h1FFFF);
    idle();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_burst();
    t_hold();
    t_nibble();
    t_step2();
    t_clear();
    t_mrst_prio();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule